// File: doc/BRIEF.md
# DRAM Fast-Page Burst Controller

This block drives an asynchronous DRAM that shares one set of address pins between row and column addresses. A client offers one request at a time. Each request carries a bus-word address, a size flag, a direction and a full line of write data. The block then runs the row and column strobes, the address mux, the read/write line, a per-beat bus-start strobe and the data pins. When the access ends it returns a one-cycle completion pulse, and for reads it also returns the captured line.

A request can be sized as a 32-byte line. Because that is larger than the 64-bit data path, it becomes four beats. The first beat carries the word the client asked for. The other three beats walk upward through the same aligned line and wrap past its end. A configuration input, sampled when the request is accepted, chooses how those beats are carried out:
- In fast-page mode, the row is opened once and only the column changes between beats.
- Otherwise, each beat gets its own complete row cycle.

A request sized as one bus word is always a single beat.

The word address is split as follows. Bits [5:0] are the column and bits [12:6] are the row. Column bits [1:0] select the word within the 32-byte line. Line data is packed by word-in-line, so slot w occupies bits [64*w+63 : 64*w].

Top module: `dfp_burst_ctrl`

## Requirements
- R1: Out of reset, and whenever idle, the block holds `req_ready`=1, `dram_ras_n`=1, `dram_cas_n`=1, `dram_bs_n`=1, `dram_dq_oe`=0 and `rsp_done`=0.
- R2: A request with `req_line`=1 performs exactly four column beats. A request with `req_line`=0 performs exactly one beat, at the requested column.
- R3: With `cfg_burst_en`=1, a line access lowers RAS once. RAS is held low across all four beats, with one pair of row states and one precharge state. `rsp_done` is observed 11 cycles after the accepting edge.
- R4: With `cfg_burst_en`=0, each beat of a line access runs two row states, two column states and a precharge. RAS falls four times, and `rsp_done` is observed 20 cycles after the accepting edge.
- R5: Beat i of a line access uses column low bits (start + i) mod 4, where start is column bits [1:0] of the request. The upper column bits and the row stay those of the request, for reads and for writes.
- R6: In the row states `dram_addr` carries the row, and in the column states it carries the column. `dram_cas_n` is low only in the second column state of each beat, so it is high between beats, and it is never low while RAS is high.
- R7: `dram_bs_n` is low for exactly one cycle per beat, in the first column state, and CAS falls in the next cycle.
- R8: For writes, `dram_rnw`=0, and `dram_dq_oe`=1 through both column states. `dram_dq_out` carries slot (word-in-line) of `req_wdata`. For reads, `dram_rnw`=1 and `dram_dq_oe` stays 0.
- R9: For reads, slot w of `rsp_rdata` takes `dram_dq_in` at the clock edge that ends the CAS-low state of the beat addressing word w. The data is valid when `rsp_done` is seen.
- R10: `rsp_done` is high for one cycle, in the final precharge state, with RAS high. `req_ready` is 0 from the accepting edge through that cycle and returns to 1 in the cycle after it.
- R11: A single-beat access shows `rsp_done` 5 cycles after the accepting edge, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_en | input | 1 | 1 selects fast-page beats; sampled at accept |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; request accepted when both are high |
| req_waddr | input | 13 | Bus-word address: row [12:6], column [5:0] |
| req_line | input | 1 | 1 = 32-byte line (four beats), 0 = one bus word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 256 | Write line, slot per word-in-line |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 256 | Read line, slot per word-in-line |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_addr | output | 7 | Multiplexed row/column address |
| dram_rnw | output | 1 | 1 = read, 0 = write |
| dram_bs_n | output | 1 | Beat-start strobe, active low |
| dram_dq_out | output | 64 | Write data to the pins |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | 64 | Read data from the pins |

## Verification
Every result is due at a fixed count of falling edges after the edge that accepts a request:
- `rsp_done` and the read line arrive at the 5th falling edge for a single beat, the 11th for a fast-page line and the 20th for a line without fast-page mode.
- `req_ready` returns one edge later.

The bench drives requests and samples all outputs on falling edges. It counts those edges from acceptance and compares the count with these figures. Its DRAM model latches the row when RAS falls and logs the column at each CAS-low edge. After `rsp_done`, the bench compares that log with the wrap order computed arithmetically, covering every start word in both directions and both modes.

// File: rtl/dfp_pkg.sv
package dfp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TR1  = 3'd1,
    ST_TR2  = 3'd2,
    ST_TC1  = 3'd3,
    ST_TC2  = 3'd4,
    ST_TPC  = 3'd5
  } dfp_state_e;
endpackage

// File: rtl/dfp_seq_fsm.sv
module dfp_seq_fsm
  import dfp_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       line_mode,
  input  logic                       page_mode,
  output dfp_state_e                 state,
  output logic [$clog2(BEATS)-1:0]   beat_idx,
  output logic                       done
);
  localparam int CNT_W = $clog2(BEATS + 1);
  localparam int IDX_W = $clog2(BEATS);

  dfp_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] n_beats;
  logic [CNT_W-1:0] cnt_inc;

  assign n_beats = line_mode ? CNT_W'(BEATS) : CNT_W'(1);
  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d  = ST_TR1;
        cnt_d = '0;
      end
      ST_TR1: st_d = ST_TR2;
      ST_TR2: st_d = ST_TC1;
      ST_TC1: st_d = ST_TC2;
      ST_TC2: begin
        cnt_d = cnt_inc;
        if (cnt_inc == n_beats)  st_d = ST_TPC;
        else if (page_mode)      st_d = ST_TC1;
        else                     st_d = ST_TPC;
      end
      ST_TPC: st_d = (cnt_q == n_beats) ? ST_IDLE : ST_TR1;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state    = st_q;
  assign beat_idx = cnt_q[IDX_W-1:0];
  assign done     = (st_q == ST_TPC) && (cnt_q == n_beats);
endmodule

// File: rtl/dfp_wrap_col.sv
module dfp_wrap_col #(
  parameter int COL_W = 6,
  parameter int IDX_W = 2
) (
  input  logic [COL_W-IDX_W-1:0] col_hi,
  input  logic [IDX_W-1:0]       start_idx,
  input  logic [IDX_W-1:0]       beat_idx,
  output logic [IDX_W-1:0]       word_idx,
  output logic [COL_W-1:0]       col
);
  // modulo-line wrap falls out of the IDX_W-bit add
  assign word_idx = start_idx + beat_idx;
  assign col      = {col_hi, word_idx};
endmodule

// File: rtl/dfp_line_buf.sv
module dfp_line_buf #(
  parameter int DATA_W = 64,
  parameter int BEATS  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap_en,
  input  logic [$clog2(BEATS)-1:0]  cap_idx,
  input  logic [DATA_W-1:0]         cap_data,
  input  logic [BEATS*DATA_W-1:0]   wr_line,
  input  logic [$clog2(BEATS)-1:0]  sel_idx,
  output logic [BEATS*DATA_W-1:0]   rd_line,
  output logic [DATA_W-1:0]         wr_word
);
  localparam int IDX_W = $clog2(BEATS);

  for (genvar g = 0; g < BEATS; g++) begin : g_slot
    logic slot_en;
    assign slot_en = cap_en && (cap_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_line[g*DATA_W +: DATA_W] <= '0;
      end else if (slot_en) begin
        rd_line[g*DATA_W +: DATA_W] <= cap_data;
      end
    end
  end

  assign wr_word = wr_line[sel_idx*DATA_W +: DATA_W];
endmodule

// File: rtl/dfp_burst_ctrl.sv
module dfp_burst_ctrl
  import dfp_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int COL_W      = 6,
  parameter int DATA_W     = 64,
  parameter int LINE_BYTES = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_burst_en,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic [ADDR_W-1:0]                      req_waddr,
  input  logic                                   req_line,
  input  logic                                   req_write,
  input  logic [(LINE_BYTES/(DATA_W/8))*DATA_W-1:0] req_wdata,
  output logic                                   rsp_done,
  output logic [(LINE_BYTES/(DATA_W/8))*DATA_W-1:0] rsp_rdata,
  output logic                                   dram_ras_n,
  output logic                                   dram_cas_n,
  output logic [((ADDR_W-COL_W) > COL_W ? (ADDR_W-COL_W) : COL_W)-1:0] dram_addr,
  output logic                                   dram_rnw,
  output logic                                   dram_bs_n,
  output logic [DATA_W-1:0]                      dram_dq_out,
  output logic                                   dram_dq_oe,
  input  logic [DATA_W-1:0]                      dram_dq_in
);
  localparam int BUS_BYTES = DATA_W / 8;
  localparam int BEATS     = LINE_BYTES / BUS_BYTES;
  localparam int IDX_W     = $clog2(BEATS);
  localparam int ROW_W     = ADDR_W - COL_W;
  localparam int MA_W      = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int LINE_W    = BEATS * DATA_W;

  // request capture, clock-enabled on acceptance
  logic              accept;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              line_q;
  logic              write_q;
  logic              page_q;
  logic [LINE_W-1:0] wdata_q;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      col_q   <= '0;
      line_q  <= 1'b0;
      write_q <= 1'b0;
      page_q  <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      row_q   <= req_waddr[ADDR_W-1:COL_W];
      col_q   <= req_waddr[COL_W-1:0];
      line_q  <= req_line;
      write_q <= req_write;
      page_q  <= cfg_burst_en;
      wdata_q <= req_wdata;
    end
  end

  dfp_state_e       st;
  logic [IDX_W-1:0] beat_idx;
  logic             seq_done;

  dfp_seq_fsm #(.BEATS(BEATS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .line_mode (line_q),
    .page_mode (page_q),
    .state     (st),
    .beat_idx  (beat_idx),
    .done      (seq_done)
  );

  logic [IDX_W-1:0] word_idx;
  logic [COL_W-1:0] col_cur;

  dfp_wrap_col #(.COL_W(COL_W), .IDX_W(IDX_W)) u_wrap (
    .col_hi    (col_q[COL_W-1:IDX_W]),
    .start_idx (col_q[IDX_W-1:0]),
    .beat_idx  (beat_idx),
    .word_idx  (word_idx),
    .col       (col_cur)
  );

  logic              cap_en;
  logic [DATA_W-1:0] wr_word;

  assign cap_en = (st == ST_TC2) && !write_q;

  dfp_line_buf #(.DATA_W(DATA_W), .BEATS(BEATS)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .cap_idx  (word_idx),
    .cap_data (dram_dq_in),
    .wr_line  (wdata_q),
    .sel_idx  (word_idx),
    .rd_line  (rsp_rdata),
    .wr_word  (wr_word)
  );

  // pin decode from registered state
  always_comb begin
    dram_ras_n  = 1'b1;
    dram_cas_n  = 1'b1;
    dram_bs_n   = 1'b1;
    dram_addr   = MA_W'(row_q);
    dram_rnw    = 1'b1;
    dram_dq_oe  = 1'b0;
    dram_dq_out = wr_word;
    case (st)
      ST_TR1: begin
        dram_rnw = !write_q;
      end
      ST_TR2: begin
        dram_ras_n = 1'b0;
        dram_rnw   = !write_q;
      end
      ST_TC1: begin
        dram_ras_n = 1'b0;
        dram_bs_n  = 1'b0;
        dram_addr  = MA_W'(col_cur);
        dram_rnw   = !write_q;
        dram_dq_oe = write_q;
      end
      ST_TC2: begin
        dram_ras_n = 1'b0;
        dram_cas_n = 1'b0;
        dram_addr  = MA_W'(col_cur);
        dram_rnw   = !write_q;
        dram_dq_oe = write_q;
      end
      default: begin
      end
    endcase
  end

  assign req_ready = (st == ST_IDLE);
  assign rsp_done  = seq_done;
endmodule

// File: rtl/dfp_burst_ctrl_chk.sv
module dfp_burst_ctrl_chk #(
  parameter int MA_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            rsp_done,
  input logic            dram_ras_n,
  input logic            dram_cas_n,
  input logic            dram_bs_n,
  input logic            dram_rnw,
  input logic            dram_dq_oe,
  input logic [MA_W-1:0] dram_addr
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dram_ras_n && dram_cas_n && dram_bs_n && !dram_dq_oe && !rsp_done)); // R1

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n); // R6

  AST_CAS_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> $stable(dram_addr)); // R6

  AST_CAS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |=> dram_cas_n); // R6

  AST_BS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_bs_n |=> (dram_bs_n && !dram_cas_n)); // R7

  AST_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> !dram_rnw); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready)); // R10

  AST_DONE_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (dram_ras_n && !req_ready)); // R10

  AST_BUSY_WITH_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> !req_ready); // R10
endmodule

bind dfp_burst_ctrl dfp_burst_ctrl_chk #(.MA_W(MA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_done   (rsp_done),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_bs_n  (dram_bs_n),
  .dram_rnw   (dram_rnw),
  .dram_dq_oe (dram_dq_oe),
  .dram_addr  (dram_addr)
);

// File: tb/dfp_burst_ctrl_tb_top.sv
`timescale 1ns/1ps
module dfp_burst_ctrl_tb_top;
  localparam int ADDR_W = 13;
  localparam int COL_W  = 6;
  localparam int DATA_W = 64;
  localparam int BEATS  = 4;
  localparam int LINE_W = BEATS * DATA_W;
  localparam int MA_W   = 7;

  logic              clk;
  logic              rst_n;
  logic              cfg_burst_en;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_waddr;
  logic              req_line;
  logic              req_write;
  logic [LINE_W-1:0] req_wdata;
  logic              rsp_done;
  logic [LINE_W-1:0] rsp_rdata;
  logic              dram_ras_n, dram_cas_n, dram_rnw, dram_bs_n, dram_dq_oe;
  logic [MA_W-1:0]   dram_addr;
  logic [DATA_W-1:0] dram_dq_out, dram_dq_in;

  dfp_burst_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_burst_en(cfg_burst_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_waddr(req_waddr),
    .req_line(req_line), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_addr(dram_addr),
    .dram_rnw(dram_rnw), .dram_bs_n(dram_bs_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- DRAM model ----------------
  logic [DATA_W-1:0] mem [int];
  int          log_n, ras_falls, bs_count, oe_err;
  int          log_row [0:7];
  int          log_col [0:7];
  int          row_lat;
  logic        ras_prev;

  function automatic logic [63:0] pattern(input int k);
    return {32'(k) ^ 32'hC0DE_0000, 32'(k) * 32'h0001_0003};
  endfunction

  function automatic logic [63:0] mem_rd(input int k);
    if (mem.exists(k)) return mem[k];
    return pattern(k);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ras_prev = 1'b1;
      row_lat  = 0;
    end else begin
      if (!dram_ras_n && ras_prev) begin
        row_lat = int'(dram_addr);
        ras_falls++;
      end
      if (!dram_bs_n) bs_count++;
      if (!dram_cas_n) begin
        if (log_n < 8) begin
          log_row[log_n] = row_lat;
          log_col[log_n] = int'(dram_addr);
        end
        log_n++;
        if (!dram_rnw) begin
          if (!dram_dq_oe) oe_err++;
          mem[row_lat * 64 + int'(dram_addr[COL_W-1:0])] = dram_dq_out;
        end else if (dram_dq_oe) begin
          oe_err++;
        end
      end
      ras_prev = dram_ras_n;
    end
  end

  always @(negedge clk) begin
    if (!dram_cas_n && dram_rnw)
      dram_dq_in <= mem_rd(row_lat * 64 + int'(dram_addr[COL_W-1:0]));
    else
      dram_dq_in <= '0;
  end

  // ---------------- stimulus ----------------
  function automatic logic [63:0] wword(input int seed, input int j);
    return {32'(seed) * 32'h0100_0193, (32'(j) ^ 32'hFACE_0000) + 32'(seed)};
  endfunction

  task automatic run_op(input int row, input int col, input bit line,
                        input bit wr, input int seed, output int cycles);
    bit busy_ok;
    @(negedge clk);
    log_n = 0; ras_falls = 0; bs_count = 0; oe_err = 0;
    req_waddr = ADDR_W'(row * 64 + col);
    req_line  = line;
    req_write = wr;
    for (int j = 0; j < BEATS; j++) req_wdata[j*DATA_W +: DATA_W] = wword(seed, j);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cycles  = 1;
    busy_ok = 1'b1;
    while (!rsp_done && cycles < 60) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      cycles++;
    end
    if (req_ready) busy_ok = 1'b0;
    chk(busy_ok, "R10", "ready low while busy", 64'(busy_ok), 64'd1);
  endtask

  task automatic after_done;
    @(negedge clk);
    chk(req_ready && !rsp_done, "R10", "ready back, done one cycle",
        {62'd0, req_ready, rsp_done}, 64'd2);
  endtask

  task automatic line_case(input bit page, input int row, input int cb, input int s);
    int cyc;
    int exp_cyc;
    int exp_ras;
    cfg_burst_en = page;
    exp_cyc = page ? 11 : 20;
    exp_ras = page ? 1 : 4;
    // write line, critical word s
    run_op(row, cb * 4 + s, 1'b1, 1'b1, row * 16 + s, cyc);
    chk(cyc == exp_cyc, page ? "R3" : "R4", "write line cycles", 64'(cyc), 64'(exp_cyc));
    chk(ras_falls == exp_ras, page ? "R3" : "R4", "write RAS falls", 64'(ras_falls), 64'(exp_ras));
    chk(log_n == 4 && bs_count == 4, "R2", "write beats/bs", 64'(log_n*16+bs_count), 64'(68));
    chk(oe_err == 0, "R8", "write oe/rnw", 64'(oe_err), 64'd0);
    for (int i = 0; i < 4; i++) begin
      int ec;
      ec = cb * 4 + ((s + i) % 4);
      chk(log_col[i] == ec && log_row[i] == row, "R5", "write beat column",
          64'(log_row[i]*64 + log_col[i]), 64'(row*64 + ec));
    end
    for (int j = 0; j < 4; j++)
      chk(mem_rd(row * 64 + cb * 4 + j) == wword(row * 16 + s, j), "R8", "written word",
          mem_rd(row * 64 + cb * 4 + j), wword(row * 16 + s, j));
    after_done();
    // read line back from a different start word
    run_op(row, cb * 4 + ((s + 1) % 4), 1'b1, 1'b0, 0, cyc);
    chk(cyc == exp_cyc, page ? "R3" : "R4", "read line cycles", 64'(cyc), 64'(exp_cyc));
    chk(ras_falls == exp_ras, page ? "R3" : "R4", "read RAS falls", 64'(ras_falls), 64'(exp_ras));
    chk(oe_err == 0, "R8", "read oe", 64'(oe_err), 64'd0);
    for (int i = 0; i < 4; i++) begin
      int ec;
      ec = cb * 4 + ((s + 1 + i) % 4);
      chk(log_col[i] == ec && log_row[i] == row, "R5", "read beat column",
          64'(log_row[i]*64 + log_col[i]), 64'(row*64 + ec));
    end
    for (int j = 0; j < 4; j++)
      chk(rsp_rdata[j*DATA_W +: DATA_W] == wword(row * 16 + s, j), "R9", "read slot",
          rsp_rdata[j*DATA_W +: DATA_W], wword(row * 16 + s, j));
    after_done();
  endtask

  task automatic single_case(input bit page, input int row, input int col);
    int cyc;
    int w;
    cfg_burst_en = page;
    w = col % 4;
    run_op(row, col, 1'b0, 1'b1, 900 + col, cyc);
    chk(cyc == 5, "R11", "single write cycles", 64'(cyc), 64'd5);
    chk(log_n == 1 && log_col[0] == col && bs_count == 1, "R2", "single write column",
        64'(log_n*1000 + log_col[0]), 64'(1000 + col));
    chk(mem_rd(row * 64 + col) == wword(900 + col, w), "R8", "single written word",
        mem_rd(row * 64 + col), wword(900 + col, w));
    after_done();
    run_op(row, col, 1'b0, 1'b0, 0, cyc);
    chk(cyc == 5 && ras_falls == 1, "R11", "single read cycles", 64'(cyc), 64'd5);
    chk(rsp_rdata[w*DATA_W +: DATA_W] == wword(900 + col, w), "R9", "single read slot",
        rsp_rdata[w*DATA_W +: DATA_W], wword(900 + col, w));
    after_done();
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_burst_en = 1'b1;
    req_valid = 1'b0;
    req_waddr = '0;
    req_line = 1'b0;
    req_write = 1'b0;
    req_wdata = '0;
    dram_dq_in = '0;
    log_n = 0; ras_falls = 0; bs_count = 0; oe_err = 0;
    repeat (3) @(negedge clk);
    chk(req_ready && dram_ras_n && dram_cas_n && dram_bs_n && !dram_dq_oe && !rsp_done,
        "R1", "reset outputs",
        {58'd0, req_ready, dram_ras_n, dram_cas_n, dram_bs_n, dram_dq_oe, rsp_done}, 64'h3C);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && dram_ras_n && dram_cas_n, "R1", "idle after reset",
        {61'd0, req_ready, dram_ras_n, dram_cas_n}, 64'h7);
    // untouched line read: pattern data, wrap from word 2
    begin
      int cyc;
      cfg_burst_en = 1'b1;
      run_op(100, 8 * 4 + 2, 1'b1, 1'b0, 0, cyc);
      for (int j = 0; j < 4; j++)
        chk(rsp_rdata[j*DATA_W +: DATA_W] == pattern(100 * 64 + 32 + j), "R9", "fresh line slot",
            rsp_rdata[j*DATA_W +: DATA_W], pattern(100 * 64 + 32 + j));
      after_done();
    end
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 4; s++)
        line_case(p[0], 5 + p * 40 + s, (3 * s + p) % 16, s);
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 4; c++)
        single_case(p[0], 90 + p, 20 + c);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule